// File: doc/BRIEF.md
# Data Memory Access Unit with Pointer Indirection

This block is the data-memory side of a small 8-bit controller. It takes one access per cycle over an 8-bit address and decides where that access lands: a file of special registers held as plain storage, a reserved window that reads as zero, a general-purpose RAM, or one of two indirect ports. The indirect ports have no storage of their own; each forwards the access to the address held in its own 8-bit pointer register.

A bank register selects, for the second indirect port only, a secondary display RAM instead of the main map. The first port is never redirected. Besides whole-byte writes, the port can set or clear a single bit of the addressed location in one cycle as a read-modify-write. Reads are combinational; every update lands on the rising clock edge.

Address layout: 00h indirect port A (pointer at 01h), 02h indirect port B (pointer at 03h), 04h bank register, 01h to 1Fh special-register storage (including 01h, 03h, 04h), 20h to 2Fh reserved, 30h to FFh general-purpose RAM.

Top module: `dmem_unit`

## Requirements
- R1: After reset every special-register location 01h to 1Fh (both pointers and the bank register included) reads 00h.
- R2: Direct addresses 01h to 1Fh and 30h to FFh hold the byte written with we_i; the write lands on the rising edge and rdata_o shows the addressed byte combinationally.
- R3: Addresses 20h to 2Fh read 00h, and byte writes or bit operations aimed at them change nothing.
- R4: An access to 00h acts on the location whose address is held at 01h; an access to 02h acts on the location whose address is held at 03h.
- R5: When an indirect port's pointer holds 00h or 02h, that port reads 00h and its writes and bit operations change nothing.
- R6: While the bank register at 04h equals 01h, accesses through 02h go to the display RAM entry selected by the low bits of the pointer at 03h (bits 4:0 for the default 32 entries); accesses through 00h are unaffected; any other bank value leaves 02h on the main map.
- R7: bset_i sets and bclr_i clears bit bit_sel_i (0 = LSB) of the addressed location, direct or indirect, leaving the other bits unchanged.
- R8: When several operations are requested in one cycle, we_i wins over bset_i, which wins over bclr_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Access address |
| wdata_i | input | 8 | Byte write data |
| we_i | input | 1 | Byte write request |
| bset_i | input | 1 | Bit set request |
| bclr_i | input | 1 | Bit clear request |
| bit_sel_i | input | 3 | Bit index for set or clear |
| rdata_o | output | 8 | Read data of the addressed location |

## Verification
The functions that meet in one cycle are pointer indirection and the single-bit read-modify-write: a bit set or clear through 00h must read the redirected location, modify one bit and write it back to that same location within one edge. The bench provokes this by aiming a pointer at general RAM and issuing a bit set through the indirect port, then reads the target directly; it also issues a bit set through a port whose pointer aims at itself and confirms the pointer register is untouched. Simultaneous we_i, bset_i and bclr_i requests are judged by reading back the byte that only the winning operation could produce.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  localparam logic [AW-1:0] IND_A_ADDR = 8'h00;
  localparam logic [AW-1:0] PTR_A_ADDR = 8'h01;
  localparam logic [AW-1:0] IND_B_ADDR = 8'h02;
  localparam logic [AW-1:0] PTR_B_ADDR = 8'h03;
  localparam logic [AW-1:0] BANK_ADDR  = 8'h04;
  localparam logic [AW-1:0] SFR_LAST   = 8'h1F;
  localparam logic [AW-1:0] GPR_BASE   = 8'h30;
  localparam logic [DW-1:0] BANK_DISP  = 8'h01;

  localparam int SFR_N = int'(SFR_LAST) + 1;
  localparam int GPR_N = (1 << AW) - int'(GPR_BASE);

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_SFR,
    TGT_GPR,
    TGT_DISP
  } tgt_e;

  // main-map class of a resolved address; the indirect ports themselves are empty
  function automatic tgt_e classify(input logic [AW-1:0] a);
    if (a == IND_A_ADDR || a == IND_B_ADDR) return TGT_NONE;
    if (a <= SFR_LAST) return TGT_SFR;
    if (a < GPR_BASE) return TGT_NONE;
    return TGT_GPR;
  endfunction
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int DISP_DEPTH = 32,
  localparam int DIW = $clog2(DISP_DEPTH)
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  ptr_a_i,
  input  logic [DW-1:0]  ptr_b_i,
  input  logic [DW-1:0]  bank_i,
  output tgt_e           tgt_o,
  output logic [AW-1:0]  eff_o,
  output logic [DIW-1:0] disp_idx_o
);
  always_comb begin
    eff_o = addr_i;
    tgt_o = classify(addr_i);
    if (addr_i == IND_A_ADDR) begin
      eff_o = ptr_a_i;
      tgt_o = classify(ptr_a_i);
    end else if (addr_i == IND_B_ADDR) begin
      eff_o = ptr_b_i;
      tgt_o = (bank_i == BANK_DISP) ? TGT_DISP : classify(ptr_b_i);
    end
  end

  assign disp_idx_o = ptr_b_i[DIW-1:0];
endmodule

// File: rtl/dmem_sfr_file.sv
module dmem_sfr_file
  import dmem_pkg::*;
#(
  parameter int N = SFR_N,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ptr_a_o,
  output logic [DW-1:0] ptr_b_o,
  output logic [DW-1:0] bank_o
);
  logic [DW-1:0] regs_q [N];

  // slot 0 is the indirect port, never stored
  assign regs_q[0] = '0;

  for (genvar g = 1; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs_q[g] <= '0;
      else if (we_i && idx_i == IW'(g))   regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[idx_i];
  assign ptr_a_o = regs_q[int'(PTR_A_ADDR)];
  assign ptr_b_o = regs_q[int'(PTR_B_ADDR)];
  assign bank_o  = regs_q[int'(BANK_ADDR)];
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/dmem_unit.sv
module dmem_unit
  import dmem_pkg::*;
#(
  parameter int DISP_DEPTH = 32,
  localparam int DIW = $clog2(DISP_DEPTH),
  localparam int GIW = $clog2(GPR_N),
  localparam int SIW = $clog2(SFR_N),
  localparam int BW  = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          bset_i,
  input  logic          bclr_i,
  input  logic [BW-1:0] bit_sel_i,
  output logic [DW-1:0] rdata_o
);
  tgt_e           tgt;
  logic [AW-1:0]  eff;
  logic [DIW-1:0] disp_idx;
  logic [DW-1:0]  ptr_a, ptr_b, bank;
  logic [DW-1:0]  sfr_rd, gpr_rd, disp_rd, cur, nxt, mask;
  logic [AW-1:0]  gpr_off;
  logic           any_op;

  dmem_decode #(.DISP_DEPTH(DISP_DEPTH)) u_dec (
    .addr_i    (addr_i),
    .ptr_a_i   (ptr_a),
    .ptr_b_i   (ptr_b),
    .bank_i    (bank),
    .tgt_o     (tgt),
    .eff_o     (eff),
    .disp_idx_o(disp_idx)
  );

  always_comb begin
    unique case (tgt)
      TGT_SFR:  cur = sfr_rd;
      TGT_GPR:  cur = gpr_rd;
      TGT_DISP: cur = disp_rd;
      default:  cur = '0;
    endcase
  end

  // priority: byte write, then set, then clear
  assign mask   = DW'(1) << bit_sel_i;
  assign any_op = we_i | bset_i | bclr_i;
  always_comb begin
    if (we_i)        nxt = wdata_i;
    else if (bset_i) nxt = cur | mask;
    else             nxt = cur & ~mask;
  end

  assign gpr_off = eff - GPR_BASE;
  assign rdata_o = cur;

  dmem_sfr_file #(.N(SFR_N)) u_sfr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (any_op && tgt == TGT_SFR),
    .idx_i  (eff[SIW-1:0]),
    .wdata_i(nxt),
    .rdata_o(sfr_rd),
    .ptr_a_o(ptr_a),
    .ptr_b_o(ptr_b),
    .bank_o (bank)
  );

  dmem_ram #(.DEPTH(GPR_N), .W(DW)) u_gpr (
    .clk_i  (clk_i),
    .we_i   (any_op && tgt == TGT_GPR),
    .idx_i  (gpr_off[GIW-1:0]),
    .wdata_i(nxt),
    .rdata_o(gpr_rd)
  );

  dmem_ram #(.DEPTH(DISP_DEPTH), .W(DW)) u_disp (
    .clk_i  (clk_i),
    .we_i   (any_op && tgt == TGT_DISP),
    .idx_i  (disp_idx),
    .wdata_i(nxt),
    .rdata_o(disp_rd)
  );
endmodule

// File: rtl/dmem_unit_chk.sv
module dmem_unit_chk
  import dmem_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          we_i,
  input logic          bset_i,
  input logic          bclr_i,
  input logic [2:0]    bit_sel_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] ptr_a_i,
  input logic [DW-1:0] ptr_b_i,
  input logic [DW-1:0] bank_i
);
  // R3
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 8'h20 && addr_i < GPR_BASE) |-> rdata_o == '0);

  // R5
  self_ind_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IND_A_ADDR && (ptr_a_i == IND_A_ADDR || ptr_a_i == IND_B_ADDR)) |-> rdata_o == '0);

  // R5
  self_ind_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IND_A_ADDR && (ptr_a_i == IND_A_ADDR || ptr_a_i == IND_B_ADDR))
    |=> ($stable(ptr_a_i) && $stable(ptr_b_i) && $stable(bank_i)));

  // R2
  ptr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PTR_A_ADDR) |=> ptr_a_i == $past(wdata_i));

  // R7
  bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bset_i && !we_i && addr_i == PTR_B_ADDR) |=> ptr_b_i[$past(bit_sel_i)] == 1'b1);

  // R8
  clr_loses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bset_i && bclr_i && !we_i && addr_i == BANK_ADDR) |=> bank_i[$past(bit_sel_i)] == 1'b1);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i || bset_i || bclr_i) |=> ($stable(ptr_a_i) && $stable(ptr_b_i) && $stable(bank_i)));
endmodule

bind dmem_unit dmem_unit_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .bset_i   (bset_i),
  .bclr_i   (bclr_i),
  .bit_sel_i(bit_sel_i),
  .rdata_o  (rdata_o),
  .ptr_a_i  (ptr_a),
  .ptr_b_i  (ptr_b),
  .bank_i   (bank)
);

// File: tb/tb_dmem_unit.sv
`timescale 1ns/1ps
module tb_dmem_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic       we_i = 1'b0, bset_i = 1'b0, bclr_i = 1'b0;
  logic [2:0] bit_sel_i = '0;
  logic [7:0] rdata_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  dmem_unit dut (.*);

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] d;
    logic       we, bs, bc;
    logic [2:0] b;
    logic [7:0] ca;
    logic [7:0] ex;
    logic [7:0] r;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{8'h30, 8'hA5, 1'b1, 1'b0, 1'b0, 3'd0, 8'h30, 8'hA5, 8'd2}, // R2 gpr low
    '{8'hFF, 8'h3C, 1'b1, 1'b0, 1'b0, 3'd0, 8'hFF, 8'h3C, 8'd2}, // R2 gpr top
    '{8'h10, 8'h77, 1'b1, 1'b0, 1'b0, 3'd0, 8'h10, 8'h77, 8'd2}, // R2 sfr
    '{8'h25, 8'h99, 1'b1, 1'b0, 1'b0, 3'd0, 8'h25, 8'h00, 8'd3}, // R3 reserved
    '{8'h01, 8'h30, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 8'hA5, 8'd4}, // R4 read via A
    '{8'h00, 8'h5A, 1'b1, 1'b0, 1'b0, 3'd0, 8'h30, 8'h5A, 8'd4}, // R4 write via A
    '{8'h03, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd0, 8'h02, 8'h3C, 8'd4}, // R4 read via B
    '{8'h01, 8'h02, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'd5}, // R5 A->02 reads 0
    '{8'h00, 8'h11, 1'b1, 1'b0, 1'b0, 3'd0, 8'h03, 8'hFF, 8'd5}, // R5 write ignored
    '{8'h04, 8'h01, 1'b1, 1'b0, 1'b0, 3'd0, 8'h04, 8'h01, 8'd2}, // R2 bank reg
    '{8'h03, 8'h05, 1'b1, 1'b0, 1'b0, 3'd0, 8'h03, 8'h05, 8'd2}, // R2 ptr B
    '{8'h02, 8'hC3, 1'b1, 1'b0, 1'b0, 3'd0, 8'h02, 8'hC3, 8'd6}, // R6 disp write
    '{8'h01, 8'h05, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'd6}, // R6 A unaffected
    '{8'h03, 8'h25, 1'b1, 1'b0, 1'b0, 3'd0, 8'h02, 8'hC3, 8'd6}, // R6 low index bits
    '{8'h04, 8'h02, 1'b1, 1'b0, 1'b0, 3'd0, 8'h02, 8'h00, 8'd6}, // R6 bank off
    '{8'h30, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 8'h30, 8'h5B, 8'd7}, // R7 set
    '{8'h30, 8'h00, 1'b0, 1'b0, 1'b1, 3'd6, 8'h30, 8'h1B, 8'd7}, // R7 clear
    '{8'hFF, 8'h80, 1'b1, 1'b1, 1'b0, 3'd0, 8'hFF, 8'h80, 8'd8}, // R8 we wins
    '{8'hFF, 8'h00, 1'b0, 1'b1, 1'b1, 3'd0, 8'hFF, 8'h81, 8'd8}, // R8 set wins
    '{8'h20, 8'h00, 1'b0, 1'b1, 1'b0, 3'd3, 8'h20, 8'h00, 8'd3}, // R3 bit op ignored
    '{8'h01, 8'h30, 1'b1, 1'b0, 1'b0, 3'd0, 8'h01, 8'h30, 8'd2}, // R2 ptr A
    '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd7, 8'h30, 8'h9B, 8'd7}, // R7 set via A
    '{8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'd5}  // R5 A->00 reads 0
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] a, input logic [7:0] d,
                    input logic we, input logic bs, input logic bc, input logic [2:0] b);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = we; bset_i = bs; bclr_i = bc; bit_sel_i = b;
    @(posedge clk_i);
    #1;
    we_i = 1'b0; bset_i = 1'b0; bclr_i = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    #12 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    peek(8'h01, v); check(v, 8'h00, "R1 ptr A");
    peek(8'h03, v); check(v, 8'h00, "R1 ptr B");
    peek(8'h04, v); check(v, 8'h00, "R1 bank");
    peek(8'h1F, v); check(v, 8'h00, "R1 sfr top");

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].a, VEC[i].d, VEC[i].we, VEC[i].bs, VEC[i].bc, VEC[i].b);
      peek(VEC[i].ca, v);
      check(v, VEC[i].ex, $sformatf("R%0d vec%0d", VEC[i].r, i));
    end

    // R5 bit set through self-aimed port leaves pointer at 00
    op(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd1);
    peek(8'h01, v); check(v, 8'h00, "R5 self bit op");

    // R6 bit op on display RAM via B with bank on
    op(8'h04, 8'h01, 1'b1, 1'b0, 1'b0, 3'd0);
    op(8'h02, 8'h00, 1'b0, 1'b0, 1'b1, 3'd0);
    peek(8'h02, v); check(v, 8'hC2, "R6 disp bit clear");
    peek(8'h25, v); check(v, 8'h00, "R6 main map untouched");

    // R1 reset again mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    peek(8'h04, v); check(v, 8'h00, "R1 bank after reset");
    peek(8'h10, v); check(v, 8'h00, "R1 sfr after reset");
    peek(8'h03, v); check(v, 8'h00, "R1 ptr B after reset");
    rst_ni = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule